// File: doc/BRIEF.md
# Posted-Write Queue with Address-Hazard Stall

This block sits between one processor's load/store port and a slow, single-ported memory. A processor store is taken into a small in-order queue in one cycle, so the processor moves on at once. The queue then sends its entries to memory one at a time. Each store occupies the memory port for a fixed number of cycles, counted by the block itself. A load whose address matches no queued store goes to memory ahead of the queued stores. A load that matches a queued store, including the one being written, is held back until that store has finished. No data is forwarded from the queue.

A strict input turns off posting. Any new access, load or store, then waits until the memory has finished every store already taken. Loads use a request/ready handshake towards memory, and a one-cycle response-valid pulse returns their data.

Top module: `wbuf_stall_top`

## Requirements
- R1: After a synchronous reset the queue is empty: `cpu_stall`, `mem_req`, `cpu_rvalid` and `drain_done` are all 0 while `cpu_req` is 0.
- R2: With strict mode off and the queue not full, a store (`cpu_we`=1) is taken with `cpu_stall`=0 in the cycle it is presented.
- R3: Stores reach memory in the order they were taken, one at a time. A store is issued as `mem_req`=1 with `mem_we`=1 (1 = write, 0 = read) in a cycle where `mem_rdy`=1. `drain_done` pulses exactly `WR_LAT` cycles after that issue cycle. `WR_LAT` defaults to 100.
- R4: A load (`cpu_we`=0) whose address equals that of any queued or in-flight store keeps `cpu_stall` high. It is issued to memory no earlier than the cycle after the `drain_done` of the last matching store.
- R5: A load that matches no queued store is issued to memory before the older stores still waiting in the queue.
- R6: A store to an address that already has a queued store is taken without a stall. Both stores drain in order, and a later load of that address returns the younger value.
- R7: When `DEPTH` stores are queued, a further store stalls. It is taken in the cycle after the next `drain_done`.
- R8: When the memory port becomes free and both an eligible load and a queued store want it, the load is issued first.
- R9: With `strict`=1, any access presented while a store is queued or in flight stalls. It is taken in the cycle after that store's `drain_done`.
- R10: A load is taken only in a cycle with `mem_rdy`=1, and `mem_req` stays high until then. `cpu_rvalid` and `cpu_rdata` follow `mem_rvalid`/`mem_rdata` by one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strict | input | 1 | 1: every access waits for all pending stores to finish |
| cpu_req | input | 1 | Processor access request, held until taken |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Access address |
| cpu_wdata | input | DW | Store data |
| cpu_stall | output | 1 | Presented access is not taken this cycle |
| cpu_rvalid | output | 1 | Load data valid (one cycle) |
| cpu_rdata | output | DW | Load data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdy | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid pulse |
| mem_rdata | input | DW | Read data |
| drain_done | output | 1 | Pulse: the in-flight store has completed |

## Verification
The hard case is the memory port freeing up in the very cycle that both a waiting load and the next queued store want it. The bench provokes this by queueing three stores and then presenting an unrelated load while the first store is still in flight. It judges the result from the logged issue cycles. The load must be issued exactly one cycle after the first `drain_done`, and the second store only after the load's data has returned. A second overlap, where a store's completion releases a hazard stall, is judged the same way: the stalled load must be taken in the cycle right after the matching `drain_done`.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    PORT_IDLE = 2'd0,
    PORT_WR   = 2'd1,
    PORT_RD   = 2'd2
  } port_st_e;
endpackage

// File: rtl/wbuf_queue.sv
module wbuf_queue #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [AW-1:0] cmp_addr,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full,
  output logic          hit
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] match;
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so a distributed RAM can hold it
  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wptr] <= push_addr;
      data_q[wptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      vld  <= '0;
    end else begin
      if (push) begin
        wptr      <= nxt(wptr);
        vld[wptr] <= 1'b1;
      end
      if (pop) begin
        rptr      <= nxt(rptr);
        vld[rptr] <= 1'b0;
      end
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // one comparator per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = vld[i] && (addr_q[i] == cmp_addr);
  end

  assign hit       = |match;
  assign empty     = (cnt == '0);
  assign full      = (cnt == CW'(DEPTH));
  assign head_addr = addr_q[rptr];
  assign head_data = data_q[rptr];

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/wbuf_port_seq.sv
module wbuf_port_seq
  import wbuf_pkg::*;
#(
  parameter int WR_LAT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_want,
  input  logic wr_pend,
  input  logic mem_rdy,
  input  logic mem_rvalid,
  output logic mem_req,
  output logic mem_we,
  output logic idle,
  output logic wr_done
);
  localparam int CW = $clog2(WR_LAT + 1);

  port_st_e      st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] chk_age;

  // a load outranks a queued store when the port is free
  assign idle    = (st == PORT_IDLE);
  assign mem_req = idle && (rd_want || wr_pend);
  assign mem_we  = idle && !rd_want && wr_pend;
  assign wr_done = (st == PORT_WR) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= PORT_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        PORT_IDLE: if (mem_req && mem_rdy) begin
          st  <= mem_we ? PORT_WR : PORT_RD;
          cnt <= CW'(WR_LAT - 1);
        end
        PORT_WR: begin
          if (cnt == '0) st <= PORT_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        PORT_RD: if (mem_rvalid) st <= PORT_IDLE;
        default: st <= PORT_IDLE;
      endcase
    end
  end

  // checker: cycles elapsed since the store was issued
  always_ff @(posedge clk) begin
    if (rst)                               chk_age <= '0;
    else if (mem_req && mem_we && mem_rdy) chk_age <= CW'(1);
    else if (st == PORT_WR)                chk_age <= chk_age + 1'b1;
  end

  assert_drain_latency_R3: assert property (@(posedge clk) disable iff (rst)
    wr_done |-> (chk_age == CW'(WR_LAT)));
  assert_single_op_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rdy) |=> !mem_req);
endmodule

// File: rtl/wbuf_stall_top.sv
module wbuf_stall_top #(
  parameter int DEPTH  = 4,
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int WR_LAT = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strict,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_stall,
  output logic          cpu_rvalid,
  output logic [DW-1:0] cpu_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rdy,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          drain_done
);
  logic          q_empty, q_full, q_hit;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  logic          strict_blk, wr_acc, rd_want, rd_acc, port_idle;

  assign strict_blk = strict && !q_empty;
  assign wr_acc     = cpu_req && cpu_we && !q_full && !strict_blk;
  assign rd_want    = cpu_req && !cpu_we && !q_hit && !strict_blk;
  assign rd_acc     = rd_want && port_idle && mem_rdy;
  assign cpu_stall  = cpu_req && !(wr_acc || rd_acc);

  wbuf_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .push      (wr_acc),
    .push_addr (cpu_addr),
    .push_data (cpu_wdata),
    .pop       (drain_done),
    .cmp_addr  (cpu_addr),
    .head_addr (head_addr),
    .head_data (head_data),
    .empty     (q_empty),
    .full      (q_full),
    .hit       (q_hit)
  );

  wbuf_port_seq #(.WR_LAT(WR_LAT)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .rd_want    (rd_want),
    .wr_pend    (!q_empty),
    .mem_rdy    (mem_rdy),
    .mem_rvalid (mem_rvalid),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .idle       (port_idle),
    .wr_done    (drain_done)
  );

  assign mem_addr  = mem_we ? head_addr : cpu_addr;
  assign mem_wdata = head_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
    end else begin
      cpu_rvalid <= mem_rvalid;
      if (mem_rvalid) cpu_rdata <= mem_rdata;
    end
  end

  assert_hit_blocks_read_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_rdy) |-> !q_hit);
  assert_strict_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (strict && !q_empty && cpu_req) |-> cpu_stall);
  assert_read_first_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && cpu_req && !cpu_we) |-> (q_hit || strict_blk));
  assert_rsp_stage_R10: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |-> $past(mem_rvalid));
  assert_done_has_entry_R3: assert property (@(posedge clk) disable iff (rst)
    drain_done |-> !q_empty);
endmodule

// File: tb/sim_wbuf_stall_top.sv
`timescale 1ns/100ps
module sim_wbuf_stall_top;
  localparam int AW = 8, DW = 16, DEPTH = 4, WR_LAT = 100, RD_LAT = 3;

  logic clk = 0, rst = 1, strict = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_stall, cpu_rvalid, mem_req, mem_we, drain_done;
  logic [DW-1:0] cpu_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic mem_rdy = 1, mem_rvalid = 0;
  logic [DW-1:0] mem_rdata = '0;

  always #2 clk = ~clk;

  wbuf_stall_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .WR_LAT(WR_LAT)) u0 (
    .clk(clk), .rst(rst), .strict(strict), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdy(mem_rdy), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .drain_done(drain_done));

  // memory model and monitor
  logic [DW-1:0] model [256];
  int cyc = 0, nw = 0, nd = 0, n_push = 0;
  int wa [64]; int wc [64]; int dc [64];
  int rd_cnt = 0, last_mrv = -10;
  logic [AW-1:0] rd_a;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (!rst) begin
      if (mem_req && mem_rdy && mem_we) begin
        model[mem_addr] <= mem_wdata; wa[nw] <= int'(mem_addr); wc[nw] <= cyc; nw <= nw + 1;
      end
      if (mem_req && mem_rdy && !mem_we) begin rd_cnt <= RD_LAT; rd_a <= mem_addr; end
      else if (rd_cnt != 0) rd_cnt <= rd_cnt - 1;
      if (drain_done) begin dc[nd] <= cyc; nd <= nd + 1; end
      if (mem_rvalid) last_mrv <= cyc;
    end
    mem_rvalid <= (rd_cnt == 1);
    mem_rdata  <= model[rd_a];
    cyc <= cyc + 1;
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_req(input bit we, input int a, input int d,
                        output int stalls, output int acc);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = DW'(d);
    stalls = 0;
    #1;
    while (cpu_stall) begin stalls++; @(negedge clk); #1; end
    acc = cyc;
    if (we) n_push++;
    @(posedge clk); #1;
    cpu_req = 0;
  endtask

  task automatic do_read(input int a, output int data, output int stalls, output int acc);
    do_req(0, a, 0, stalls, acc);
    @(negedge clk);
    while (!cpu_rvalid) @(negedge clk);
    data = int'(cpu_rdata);
    check_eq("R10 response one stage after memory", cyc, last_mrv + 1);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (nd != n_push) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_eq("R1 stall after reset", int'(cpu_stall), 0);
    check_eq("R1 mem_req after reset", int'(mem_req), 0);
    check_eq("R1 rvalid after reset", int'(cpu_rvalid), 0);
    check_eq("R1 drain_done after reset", int'(drain_done), 0);
  endtask

  task automatic t_basic();
    int s, a, d, i0, d0;
    i0 = nw; d0 = nd;
    do_req(1, 'h10, 'h1111, s, a);
    check_eq("R2 store taken without stall", s, 0);
    wait_idle();
    check_eq("R3 write latency", dc[d0] - wc[i0], WR_LAT);
    do_read('h10, d, s, a);
    check_eq("R10 load data after drain", d, 'h1111);
  endtask

  task automatic t_order();
    int s0, s1, s2, s, a, d, ra, i0, d0;
    i0 = nw; d0 = nd;
    do_req(1, 'h20, 'h2020, s0, a);
    do_req(1, 'h21, 'h2121, s1, a);
    do_req(1, 'h22, 'h2222, s2, a);
    check_eq("R2 back-to-back stores no stall", s0 + s1 + s2, 0);
    do_read('h30, d, s, ra);
    wait_idle();
    check_eq("R3 drain order first", wa[i0], 'h20);
    check_eq("R3 drain order second", wa[i0+1], 'h21);
    check_eq("R3 drain order third", wa[i0+2], 'h22);
    check_eq("R8 load issued right after done", ra, dc[d0] + 1);
    check_eq("R5 load ahead of older store", int'(ra < wc[i0+1]), 1);
    check_eq("R5 bypass load data", d, 'hA530);
  endtask

  task automatic t_hazard();
    int s, a, d, ra, d0;
    d0 = nd;
    do_req(1, 'h40, 'hBEEF, s, a);
    do_req(1, 'h41, 'hCAFE, s, a);
    do_read('h41, d, s, ra);
    check_eq("R4 hazard load stalled", int'(s > 0), 1);
    check_eq("R4 released after matching done", ra, dc[d0+1] + 1);
    check_eq("R4 hazard load data", d, 'hCAFE);
    wait_idle();
  endtask

  task automatic t_same();
    int s0, s1, s, a, d, ra, i0, d0;
    i0 = nw; d0 = nd;
    do_req(1, 'h50, 'h0001, s0, a);
    do_req(1, 'h50, 'h0002, s1, a);
    check_eq("R6 same-address store no stall", s0 + s1, 0);
    do_read('h50, d, s, ra);
    check_eq("R6 younger value returned", d, 'h0002);
    check_eq("R6 load after second done", ra, dc[d0+1] + 1);
    check_eq("R6 both drained", int'(wa[i0] == 'h50 && wa[i0+1] == 'h50), 1);
    wait_idle();
  endtask

  task automatic t_full();
    int s, a, tot, d0;
    d0 = nd; tot = 0;
    for (int k = 0; k < DEPTH; k++) begin
      do_req(1, 'h60 + k, 'h600 + k, s, a);
      tot += s;
    end
    check_eq("R7 fill without stall", tot, 0);
    do_req(1, 'h6F, 'h6FF, s, a);
    check_eq("R7 full store stalled", int'(s > 0), 1);
    check_eq("R7 taken after one drain", a, dc[d0] + 1);
    wait_idle();
  endtask

  task automatic t_strict();
    int s, a, d, ra, d0;
    d0 = nd;
    @(negedge clk); strict = 1;
    do_req(1, 'h70, 'h7070, s, a);
    check_eq("R9 first strict store free", s, 0);
    do_req(1, 'h71, 'h7171, s, a);
    check_eq("R9 store waits for ack", a, dc[d0] + 1);
    do_read('h72, d, s, ra);
    check_eq("R9 load waits for ack", ra, dc[d0+1] + 1);
    check_eq("R9 load data", d, 'hA572);
    @(negedge clk); strict = 0;
    wait_idle();
  endtask

  task automatic t_rdy();
    int s, ra, d;
    @(negedge clk); mem_rdy = 0;
    fork
      do_read('h33, d, s, ra);
      begin
        repeat (3) @(negedge clk);
        #1;
        check_eq("R10 request held while not ready", int'(mem_req && !mem_we), 1);
        check_eq("R10 stall while not ready", int'(cpu_stall), 1);
        @(negedge clk); mem_rdy = 1;
      end
    join
    check_eq("R10 load waits for ready", int'(s >= 3), 1);
    check_eq("R10 data after ready", d, 'hA533);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 16'hA500 | DW'(i);
    repeat (4) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_basic();
    t_order();
    t_hazard();
    t_same();
    t_full();
    t_strict();
    t_rdy();
    repeat (5) @(negedge clk);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    summary();
  end
endmodule